// File: doc/BRIEF.md
# Byte FIFO Pair with Event and Interrupt Logic

This block sits between a 32-bit register port and a serial shift engine. It holds two byte-wide FIFOs. The transmit FIFO is filled from register writes and drained one byte at a time by the engine. The receive FIFO is filled one byte at a time by the engine and drained by register reads. The register side can move either a packed 32-bit word, big-endian (the earliest byte sits in bits 31:24), or a single byte in bits 7:0. A size flag on each strobe selects which.

Two sticky event bits report progress. One says the receive FIFO holds more bytes than its threshold. The other says the transmit FIFO has more free space than its threshold. Software clears an event by writing a one to it. While its condition still holds, the event comes back on the next cycle. A mask register picks which events drive the single interrupt output. The event register also shows both byte counts, so software can see how much to move without any more reads.

Register select codes on `wr_sel`/`rd_sel`: 0 mode, 1 event, 2 mask, 3 transmit data, 4 receive data. A size flag of 1 means a single-byte access.

Top module: `spi_fifo_evt_top`

## Requirements
- R1: After a cycle with `rst_n` low, both counts are zero, both events are clear, the mask is zero, `irq` is 0, `rd_data` is 0, and the thresholds are 4 (transmit) and 3 (receive).
- R2: A word write to select 3 queues four bytes, bits 31:24 first. A byte write queues bits 7:0. `eng_tx_valid` is high whenever the transmit count is nonzero, and `eng_tx_data` shows the oldest byte. `eng_tx_take` removes one byte and is ignored when the FIFO is empty.
- R3: A transmit write is dropped whole if the free space before that cycle is smaller than the bytes it carries (4 or 1).
- R4: A word read of select 4 returns four bytes on `rd_data` one cycle later, with the oldest in bits 31:24, and removes them. With fewer than four bytes stored it returns 0 and removes nothing.
- R5: A byte read of select 4 returns the oldest byte in bits 7:0, with the upper bits zero, and removes it. When the FIFO is empty it returns 0 and the count stays the same.
- R6: `eng_rx_put` stores `eng_rx_data` unless the receive FIFO already holds DEPTH bytes. In that case the byte is lost.
- R7: A read of select 1 returns the receive event in bit 9, the transmit event in bit 8, the receive count in bits 29:24 and the transmit count in bits 21:16. All other bits are zero. The values are those held before that cycle.
- R8: The receive event sets one cycle after any cycle in which the receive count is above the receive threshold. It stays set until cleared.
- R9: The transmit event sets one cycle after any cycle in which DEPTH minus the transmit count is above the transmit threshold. It stays set until cleared.
- R10: Writing select 1 with bit 9 or bit 8 at 1 clears that event on the next edge. Zeros leave the event unchanged. If the condition still holds, the event sets again one cycle later.
- R11: The mask register (select 2) keeps bits 9 and 8 only. `irq` is high exactly when some event bit is set and its mask bit is also set.
- R12: The mode register (select 1 is events; select 0 is mode) holds the transmit threshold in the field that starts at bit 8 and the receive threshold in the field that starts at bit 0. Each field is $clog2(DEPTH)+1 bits wide. Reads return only those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_byte | input | 1 | 1 = single-byte write, 0 = word write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 3 | Register select for the read |
| rd_byte | input | 1 | 1 = single-byte read, 0 = word read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` and held until the next read |
| eng_tx_valid | output | 1 | Transmit FIFO holds at least one byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_take | input | 1 | Engine consumes the oldest transmit byte |
| eng_rx_put | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| irq | output | 1 | OR of the events enabled by the mask |

## Verification
The bench builds the block with DEPTH set to 8, keeping the default thresholds of 4 and 3. With eight bytes, a few writes fill the transmit FIFO, so dropped word and byte writes are easy to reach. The threshold crossings come within one or two bytes of the boundary. A fill of the receive FIFO past capacity takes only ten pushes. The narrow 4-bit threshold fields also make the read-back of the mode register with junk in the upper bits meaningful.

// File: rtl/fifo_evt_pkg.sv
// Shared register codes and status-word layout for the byte FIFO pair.
// Assumes counts and thresholds are at most 6 bits wide (DEPTH <= 32).
package fifo_evt_pkg;

    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_EVENT = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_TXD   = 3'd3,
        SEL_RXD   = 3'd4
    } reg_sel_e;

    localparam int EV_RX_BIT   = 9;
    localparam int EV_TX_BIT   = 8;
    localparam int RXCNT_LSB   = 24;
    localparam int TXCNT_LSB   = 16;
    localparam int CNT_FIELD_W = 6;
    localparam int TXTHR_LSB   = 8;
    localparam int RXTHR_LSB   = 0;

    // Builds the event/status word from counts and event bits
    function automatic logic [31:0] pack_status(
        input logic [CNT_FIELD_W-1:0] rxc,
        input logic [CNT_FIELD_W-1:0] txc,
        input logic                   ev_rx,
        input logic                   ev_tx
    );
        logic [31:0] w;
        w = '0;
        w[RXCNT_LSB +: CNT_FIELD_W] = rxc;
        w[TXCNT_LSB +: CNT_FIELD_W] = txc;
        w[EV_RX_BIT] = ev_rx;
        w[EV_TX_BIT] = ev_tx;
        return w;
    endfunction

endpackage

// File: rtl/fifo_byte_ring.sv
// Byte ring buffer that can push up to PUSH_LANES bytes and pop up to
// POP_LANES bytes per cycle. A request is taken whole or not at all, judged
// against the occupancy held before the cycle. Lane 0 is the oldest byte and
// sits in the most significant byte of the packed data. DEPTH must be a power
// of two and at least as large as either lane count.
module fifo_byte_ring #(
    parameter int DEPTH      = 32,
    parameter int PUSH_LANES = 4,
    parameter int POP_LANES  = 1,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int CNT_W     = PTR_W + 1,
    localparam int PU_W      = $clog2(PUSH_LANES) + 1,
    localparam int PO_W      = $clog2(POP_LANES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PU_W-1:0]         push_n,
    input  logic [8*PUSH_LANES-1:0] push_data,
    input  logic [PO_W-1:0]         pop_n,
    output logic [8*POP_LANES-1:0]  peek_data,
    output logic [CNT_W-1:0]        count
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] free_sp;
    logic             push_ok;
    logic             pop_ok;
    logic [CNT_W-1:0] push_amt;
    logic [CNT_W-1:0] pop_amt;

    // Acceptance: whole request must fit in the space or data present
    always_comb begin
        free_sp  = CNT_W'(DEPTH) - count;
        push_ok  = (push_n != '0) && (CNT_W'(push_n) <= free_sp);
        pop_ok   = (pop_n != '0) && (CNT_W'(pop_n) <= count);
        push_amt = push_ok ? CNT_W'(push_n) : '0;
        pop_amt  = pop_ok ? CNT_W'(pop_n) : '0;
    end

    // Storage write: lane i lands at write pointer plus i
    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_LANES; i++) begin
            if (push_ok && (i < int'(push_n))) begin
                mem[wr_ptr + PTR_W'(i)] <= push_data[8*(PUSH_LANES-1-i) +: 8];
            end
        end
    end

    // Oldest POP_LANES bytes presented, oldest in the top byte
    for (genvar g = 0; g < POP_LANES; g++) begin : g_peek
        logic [PTR_W-1:0] addr;
        assign addr = rd_ptr + PTR_W'(g);
        assign peek_data[8*(POP_LANES-1-g) +: 8] = mem[addr];
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_amt);
            rd_ptr <= rd_ptr + PTR_W'(pop_amt);
            count  <= count + push_amt - pop_amt;
        end
    end

endmodule

// File: rtl/fifo_evt_ctrl.sv
// Threshold, event, mask and interrupt logic. Events are sticky and set
// from the registered counts. A write-one clear wins over a set in the
// same cycle, so a held condition re-arms the event one cycle later.
module fifo_evt_ctrl #(
    parameter int DEPTH      = 32,
    parameter int TX_THR_RST = 4,
    parameter int RX_THR_RST = 3,
    localparam int CNT_W     = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             mode_we,
    input  logic [CNT_W-1:0] mode_tx_thr,
    input  logic [CNT_W-1:0] mode_rx_thr,
    input  logic [1:0]       evt_clr,
    input  logic             mask_we,
    input  logic [1:0]       mask_wdata,
    output logic [CNT_W-1:0] tx_thr,
    output logic [CNT_W-1:0] rx_thr,
    output logic [1:0]       ev_bits,
    output logic [1:0]       mask_bits,
    output logic             irq
);

    logic [1:0] cond;

    // Event conditions: bit 1 receive level, bit 0 transmit room
    always_comb begin
        cond[1] = rx_count > rx_thr;
        cond[0] = (CNT_W'(DEPTH) - tx_count) > tx_thr;
    end

    // Mode, mask and sticky event registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr    <= CNT_W'(TX_THR_RST);
            rx_thr    <= CNT_W'(RX_THR_RST);
            ev_bits   <= '0;
            mask_bits <= '0;
        end else begin
            if (mode_we) begin
                tx_thr <= mode_tx_thr;
                rx_thr <= mode_rx_thr;
            end
            if (mask_we) begin
                mask_bits <= mask_wdata;
            end
            for (int i = 0; i < 2; i++) begin
                if (evt_clr[i]) begin
                    ev_bits[i] <= 1'b0;
                end else if (cond[i]) begin
                    ev_bits[i] <= 1'b1;
                end
            end
        end
    end

    // Interrupt: any enabled event
    assign irq = |(ev_bits & mask_bits);

endmodule

// File: rtl/spi_fifo_evt_top.sv
// Register-side wrapper for the transmit and receive byte FIFOs. It decodes
// the read and write strobes and packs words big-endian. It also builds the
// status word and registers the read data. Assumes DEPTH is a power of two
// from 4 to 32.
module spi_fifo_evt_top
    import fifo_evt_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int TX_THR_RST = 4,
    parameter int RX_THR_RST = 3,
    localparam int CNT_W     = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic        wr_byte,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [2:0]  rd_sel,
    input  logic        rd_byte,
    output logic [31:0] rd_data,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_tx_take,
    input  logic        eng_rx_put,
    input  logic [7:0]  eng_rx_data,
    output logic        irq
);

    logic [CNT_W-1:0] tx_count;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] tx_thr;
    logic [CNT_W-1:0] rx_thr;
    logic [1:0]       ev_bits;
    logic [1:0]       mask_bits;
    logic [2:0]       tx_push_n;
    logic [31:0]      tx_push_data;
    logic [2:0]       rx_pop_n;
    logic [31:0]      rx_peek;
    logic             rx_rd;
    logic             rx_have;
    logic [1:0]       evt_clr;
    logic             mode_we;
    logic             mask_we;
    logic [31:0]      rd_mux;

    // Transmit push request: four bytes for a word, low byte for a byte write
    always_comb begin
        tx_push_n    = '0;
        tx_push_data = wr_byte ? {wr_data[7:0], 24'h0} : wr_data;
        if (wr_en && (wr_sel == SEL_TXD)) begin
            tx_push_n = wr_byte ? 3'd1 : 3'd4;
        end
    end

    // Receive pop request and whether enough bytes are present for it
    always_comb begin
        rx_rd    = rd_en && (rd_sel == SEL_RXD);
        rx_pop_n = rx_rd ? (rd_byte ? 3'd1 : 3'd4) : 3'd0;
        rx_have  = rx_count >= (rd_byte ? CNT_W'(1) : CNT_W'(4));
    end

    // Control-register write decode
    always_comb begin
        mode_we = wr_en && (wr_sel == SEL_MODE);
        mask_we = wr_en && (wr_sel == SEL_MASK);
        evt_clr = (wr_en && (wr_sel == SEL_EVENT)) ?
                  {wr_data[EV_RX_BIT], wr_data[EV_TX_BIT]} : 2'b00;
    end

    fifo_byte_ring #(
        .DEPTH      (DEPTH),
        .PUSH_LANES (4),
        .POP_LANES  (1)
    ) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (tx_push_n),
        .push_data (tx_push_data),
        .pop_n     (eng_tx_take),
        .peek_data (eng_tx_data),
        .count     (tx_count)
    );

    fifo_byte_ring #(
        .DEPTH      (DEPTH),
        .PUSH_LANES (1),
        .POP_LANES  (4)
    ) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (eng_rx_put),
        .push_data (eng_rx_data),
        .pop_n     (rx_pop_n),
        .peek_data (rx_peek),
        .count     (rx_count)
    );

    fifo_evt_ctrl #(
        .DEPTH      (DEPTH),
        .TX_THR_RST (TX_THR_RST),
        .RX_THR_RST (RX_THR_RST)
    ) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_count    (rx_count),
        .tx_count    (tx_count),
        .mode_we     (mode_we),
        .mode_tx_thr (wr_data[TXTHR_LSB +: CNT_W]),
        .mode_rx_thr (wr_data[RXTHR_LSB +: CNT_W]),
        .evt_clr     (evt_clr),
        .mask_we     (mask_we),
        .mask_wdata  ({wr_data[EV_RX_BIT], wr_data[EV_TX_BIT]}),
        .tx_thr      (tx_thr),
        .rx_thr      (rx_thr),
        .ev_bits     (ev_bits),
        .mask_bits   (mask_bits),
        .irq         (irq)
    );

    assign eng_tx_valid = (tx_count != '0);

    // Read multiplexer over the five register codes
    always_comb begin
        rd_mux = '0;
        case (rd_sel)
            SEL_MODE: begin
                rd_mux[TXTHR_LSB +: CNT_W] = tx_thr;
                rd_mux[RXTHR_LSB +: CNT_W] = rx_thr;
            end
            SEL_EVENT: rd_mux = pack_status(CNT_FIELD_W'(rx_count),
                                            CNT_FIELD_W'(tx_count),
                                            ev_bits[1], ev_bits[0]);
            SEL_MASK: begin
                rd_mux[EV_RX_BIT] = mask_bits[1];
                rd_mux[EV_TX_BIT] = mask_bits[0];
            end
            SEL_RXD: begin
                if (rx_have) begin
                    rd_mux = rd_byte ? {24'h0, rx_peek[31:24]} : rx_peek;
                end
            end
            default: rd_mux = '0;
        endcase
    end

    // Read data register, loaded on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/spi_fifo_evt_chk.sv
// Property checker for spi_fifo_evt_top, attached by bind below. It watches
// the strobes, the byte counts and the receive event bit.
module spi_fifo_evt_chk
    import fifo_evt_pkg::*;
#(
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic             wr_byte,
    input logic             clr_rx,
    input logic             rd_en,
    input logic [2:0]       rd_sel,
    input logic             rd_byte,
    input logic [31:0]      rd_data,
    input logic             eng_tx_take,
    input logic             eng_rx_put,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             ev_rx,
    input logic [CNT_W-1:0] rx_thr
);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH)));

    // R3
    tx_word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_TXD) && !wr_byte && !eng_tx_take &&
         (tx_count > CNT_W'(DEPTH - 4))) |=> $stable(tx_count));

    // R5
    empty_byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_sel == SEL_RXD) && rd_byte && (rx_count == '0) && !eng_rx_put)
        |=> ((rx_count == '0) && (rd_data == 32'h0)));

    // R4
    short_word_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_sel == SEL_RXD) && !rd_byte && (rx_count < CNT_W'(4)) && !eng_rx_put)
        |=> ($stable(rx_count) && (rd_data == 32'h0)));

    // R10
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_EVENT) && clr_rx) |=> !ev_rx);

    // R8
    rx_event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_rx && (rx_count > rx_thr) && !(wr_en && (wr_sel == SEL_EVENT) && clr_rx))
        |=> ev_rx);

endmodule

bind spi_fifo_evt_top spi_fifo_evt_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_byte     (wr_byte),
    .clr_rx      (wr_data[9]),
    .rd_en       (rd_en),
    .rd_sel      (rd_sel),
    .rd_byte     (rd_byte),
    .rd_data     (rd_data),
    .eng_tx_take (eng_tx_take),
    .eng_rx_put  (eng_rx_put),
    .tx_count    (tx_count),
    .rx_count    (rx_count),
    .ev_rx       (ev_bits[1]),
    .rx_thr      (rx_thr)
);

// File: tb/tb_spi_fifo_evt_top.sv
// Bench: a behavioural queue model is stepped with the same inputs each
// clock, and all outputs are compared after every edge.
module tb_spi_fifo_evt_top;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en, wr_byte, rd_en, rd_byte, eng_tx_take, eng_rx_put;
    logic [2:0]  wr_sel, rd_sel;
    logic [31:0] wr_data;
    logic [7:0]  eng_rx_data;
    logic [31:0] rd_data;
    logic        eng_tx_valid, irq;
    logic [7:0]  eng_tx_data;

    int total = 0;
    int fails = 0;
    bit done  = 0;
    string cur_tag = "R1";

    // Reference model state
    logic [7:0]  tx_q[$];
    logic [7:0]  rx_q[$];
    bit          m_ev_rx, m_ev_tx, m_mk_rx, m_mk_tx;
    int          m_txthr = 4, m_rxthr = 3;
    logic [31:0] m_rd = '0;

    always #4 clk = ~clk;

    spi_fifo_evt_top #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_byte(rd_byte),
        .rd_data(rd_data), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_take(eng_tx_take), .eng_rx_put(eng_rx_put), .eng_rx_data(eng_rx_data),
        .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_sel = 0; wr_byte = 0; wr_data = 0;
        rd_en = 0; rd_sel = 0; rd_byte = 0;
        eng_tx_take = 0; eng_rx_put = 0; eng_rx_data = 0;
    endtask

    // Applies one clock of the current inputs to the model
    task automatic model_step();
        int rxc = rx_q.size();
        int txc = tx_q.size();
        bit cond_rx = rxc > m_rxthr;
        bit cond_tx = (DEPTH - txc) > m_txthr;
        bit clr_rx = 0, clr_tx = 0;
        logic [31:0] rv = 0;
        if (!rst_n) begin
            tx_q.delete(); rx_q.delete();
            m_ev_rx = 0; m_ev_tx = 0; m_mk_rx = 0; m_mk_tx = 0;
            m_txthr = 4; m_rxthr = 3; m_rd = 0;
            return;
        end
        if (rd_en) begin
            case (rd_sel)
                3'd0: rv = (32'(m_txthr) << 8) | 32'(m_rxthr);
                3'd1: rv = (32'(rxc) << 24) | (32'(txc) << 16) |
                           (32'(m_ev_rx) << 9) | (32'(m_ev_tx) << 8);
                3'd2: rv = (32'(m_mk_rx) << 9) | (32'(m_mk_tx) << 8);
                3'd4: begin
                    if (rd_byte && rxc >= 1) begin
                        rv = 32'(rx_q.pop_front());
                    end else if (!rd_byte && rxc >= 4) begin
                        rv = {rx_q[0], rx_q[1], rx_q[2], rx_q[3]};
                        for (int k = 0; k < 4; k++) void'(rx_q.pop_front());
                    end
                end
                default: rv = 0;
            endcase
            m_rd = rv;
        end
        if (eng_tx_take && txc >= 1) void'(tx_q.pop_front());
        if (eng_rx_put && rxc < DEPTH) rx_q.push_back(eng_rx_data);
        if (wr_en) begin
            case (wr_sel)
                3'd0: begin
                    m_txthr = int'(wr_data[11:8]);
                    m_rxthr = int'(wr_data[3:0]);
                end
                3'd1: begin
                    clr_rx = wr_data[9];
                    clr_tx = wr_data[8];
                end
                3'd2: begin
                    m_mk_rx = wr_data[9];
                    m_mk_tx = wr_data[8];
                end
                3'd3: begin
                    if (wr_byte && (DEPTH - txc) >= 1) begin
                        tx_q.push_back(wr_data[7:0]);
                    end else if (!wr_byte && (DEPTH - txc) >= 4) begin
                        tx_q.push_back(wr_data[31:24]);
                        tx_q.push_back(wr_data[23:16]);
                        tx_q.push_back(wr_data[15:8]);
                        tx_q.push_back(wr_data[7:0]);
                    end
                end
                default: ;
            endcase
        end
        m_ev_rx = clr_rx ? 1'b0 : (m_ev_rx | cond_rx);
        m_ev_tx = clr_tx ? 1'b0 : (m_ev_tx | cond_tx);
    endtask

    task automatic compare();
        bit exp_irq = (m_ev_rx & m_mk_rx) | (m_ev_tx & m_mk_tx);
        chk("R11", 32'(irq), 32'(exp_irq));
        chk("R2", 32'(eng_tx_valid), 32'(tx_q.size() != 0));
        if (tx_q.size() != 0) chk("R2", 32'(eng_tx_data), 32'(tx_q[0]));
        chk(cur_tag, rd_data, m_rd);
    endtask

    task automatic tick(string tag);
        cur_tag = tag;
        model_step();
        @(posedge clk);
        #2;
        compare();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d, logic by, string tag);
        wr_en = 1; wr_sel = sel; wr_data = d; wr_byte = by;
        tick(tag);
    endtask

    task automatic rd(logic [2:0] sel, logic by, string tag);
        rd_en = 1; rd_sel = sel; rd_byte = by;
        tick(tag);
    endtask

    task automatic put_rx(logic [7:0] b, string tag);
        eng_rx_put = 1; eng_rx_data = b;
        tick(tag);
    endtask

    initial begin
        idle_inputs();
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick("R1");
        rst_n = 1;
        // R1 defaults and first-cycle status
        rd(3'd1, 0, "R1");
        rd(3'd0, 0, "R1");
        rd(3'd2, 0, "R1");
        // R9 transmit room event, R11 mask
        rd(3'd1, 0, "R9");
        wr(3'd2, 32'h100, 0, "R11");
        wr(3'd2, 32'h200, 0, "R11");
        // R2 word and byte pushes
        wr(3'd3, 32'hA1B2C3D4, 0, "R2");
        wr(3'd1, 32'h100, 0, "R10");
        rd(3'd1, 0, "R7");
        wr(3'd3, 32'h00000055, 1, "R2");
        // R3 dropped writes
        wr(3'd3, 32'hDEADBEEF, 0, "R3");
        for (int i = 0; i < 3; i++) wr(3'd3, 32'h60 + i, 1, "R2");
        wr(3'd3, 32'h77, 1, "R3");
        rd(3'd1, 0, "R3");
        // Drain transmit, one extra take on empty
        for (int i = 0; i < 9; i++) begin eng_tx_take = 1; tick("R2"); end
        // R10 clear while condition holds
        wr(3'd1, 32'h300, 0, "R10");
        rd(3'd1, 0, "R10");
        rd(3'd1, 0, "R10");
        wr(3'd1, 32'h0, 0, "R10");
        rd(3'd1, 0, "R10");
        // R5 and R4 on empty receive FIFO
        rd(3'd4, 1, "R5");
        rd(3'd4, 0, "R4");
        // R8 receive level event, packed reads
        for (int i = 0; i < 5; i++) put_rx(8'h10 + 8'(i), "R8");
        rd(3'd1, 0, "R8");
        rd(3'd4, 0, "R4");
        rd(3'd4, 1, "R5");
        rd(3'd4, 1, "R5");
        for (int i = 0; i < 3; i++) put_rx(8'h20 + 8'(i), "R6");
        rd(3'd4, 0, "R4");
        rd(3'd1, 0, "R4");
        for (int i = 0; i < 3; i++) rd(3'd4, 1, "R5");
        // R6 overfill
        for (int i = 0; i < 10; i++) put_rx(8'h30 + 8'(i), "R6");
        rd(3'd1, 0, "R6");
        rd(3'd4, 0, "R6");
        rd(3'd4, 0, "R6");
        // R12 mode fields and R8 threshold boundary
        wr(3'd0, 32'h0205, 0, "R12");
        rd(3'd0, 0, "R12");
        wr(3'd0, 32'hFFFFF2F5, 0, "R12");
        rd(3'd0, 0, "R12");
        wr(3'd1, 32'h200, 0, "R8");
        for (int i = 0; i < 5; i++) put_rx(8'h40 + 8'(i), "R8");
        rd(3'd1, 0, "R8");
        put_rx(8'h45, "R8");
        rd(3'd1, 0, "R8");
        // Simultaneous register and engine traffic
        wr_en = 1; wr_sel = 3'd3; wr_data = 32'h01020304; eng_tx_take = 1;
        rd_en = 1; rd_sel = 3'd4; rd_byte = 1; eng_rx_put = 1; eng_rx_data = 8'h99;
        tick("R5");
        // Mixed traffic
        void'($urandom(32'd11));
        for (int n = 0; n < 600; n++) begin
            wr_en = ($urandom_range(0, 99) < 35);
            wr_sel = 3'($urandom_range(0, 4));
            wr_data = $urandom;
            wr_byte = 1'($urandom_range(0, 1));
            rd_en = ($urandom_range(0, 2) == 0);
            rd_sel = 3'($urandom_range(0, 5));
            rd_byte = 1'($urandom_range(0, 1));
            eng_tx_take = ($urandom_range(0, 2) == 0);
            eng_rx_put = 1'($urandom_range(0, 1));
            eng_rx_data = 8'($urandom);
            tick(rd_sel == 3'd4 ? "R4" : "R7");
        end
        // R1 reset mid-run
        rst_n = 0;
        tick("R1");
        tick("R1");
        rst_n = 1;
        rd(3'd1, 0, "R1");
        rd(3'd0, 0, "R1");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            fails++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule